// File: doc/BRIEF.md
# Reciprocal Low-Frequency Meter

This block measures the frequency of a slow, synchronous digital input in the 1 Hz to 10 Hz range. It does not count pulses over a gate time. On a start request it times one full period of the input in whole milliseconds, divides the constant 100,000 by that period, and turns the quotient into four decimal digits. The result is the input frequency in hundredths of a hertz, from 0100 (1.00 Hz) up to 1000 (10.00 Hz).

Internally a small sequencing controller runs three sub-units in turn: a period timer (edge detector plus a millisecond prescaler), a sequential restoring divider, and a sequential shift-and-add-3 binary-to-decimal converter. Each sub-unit gets a one-cycle start and answers with a one-cycle done. All pins are plain control and status. There is no data stream and so no valid/ready handshake. One result is produced per accepted start, and it is held on `bcd_o` until the next result replaces it, so the consumer never needs to apply back-pressure. The input must already be synchronous to `clk`. `CYCLES_PER_MS` must be at least 2 (50,000 for a 50 MHz clock).

Top module: `lfm_meter`

## Requirements
- R1: While `rst` is high and after it is released, `ready` = 1, `done_tick` = 0 and `bcd_o` = 0.
- R2: `ready` is 1 only while the meter is idle. A `start` seen while `ready` = 1 drops `ready` on the next cycle. A `start` pulse while busy is ignored: it causes no extra result and does not change the result in progress.
- R3: The period in milliseconds is floor(N / `CYCLES_PER_MS`). N is the number of clock cycles between the first two consecutive rising edges of `sig_in` (a 0 in one cycle, then a 1 in the next) that are seen after the start.
- R4: The millisecond prescaler count never leaves the range 0 to `CYCLES_PER_MS`-1.
- R5: The quotient is floor(100,000 / period_ms), computed by restoring division one bit per cycle. While dividing, the partial remainder stays below a nonzero divisor.
- R6: `bcd_o` holds the quotient as four decimal digits: thousands in [15:12], hundreds in [11:8], tens in [7:4], units in [3:0]. Every digit is 0 to 9.
- R7: `done_tick` is high for exactly one cycle. It rises in the same cycle that the new `bcd_o` value appears, and `ready` is 1 in that cycle.
- R8: `bcd_o` does not change in any cycle where `done_tick` is 0, including while a new measurement is running.
- R9: At most one sub-unit reports done in any cycle. The sub-units run in the order period, divide, convert.
- R10: If `sig_in` is already high when `start` is accepted, that level does not count as an edge. Timing begins at the next 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | One-cycle request to begin a measurement |
| sig_in | input | 1 | Synchronous input whose frequency is measured |
| ready | output | 1 | High while idle and able to accept `start` |
| done_tick | output | 1 | One-cycle pulse when a new result is on `bcd_o` |
| bcd_o | output | 16 | Frequency in 0.01 Hz as four decimal digits |

## Verification
The bench builds the meter with `CYCLES_PER_MS` = 2 and leaves the other parameters at their defaults. This turns the 100 ms to 1000 ms period range into 200 to 2001 clock cycles, so the whole range, including both ends, fits in a short run. Each square-wave period is P·2 + j cycles with j of 0 or 1. This checks the truncation rule of R3 against the same floor division used by the expected-value function. Random start phases put some starts inside a high phase (R10). A second start during a busy measurement exercises the ignore rule.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {TOP_IDLE, TOP_COUNT, TOP_FRQ, TOP_B2B} top_state_t;
  typedef enum logic [1:0] {PRD_IDLE, PRD_WAIT, PRD_COUNT, PRD_DONE} prd_state_t;
  typedef enum logic [1:0] {DIV_IDLE, DIV_OP, DIV_LAST, DIV_DONE} div_state_t;
  typedef enum logic [1:0] {CNV_IDLE, CNV_OP, CNV_DONE} cnv_state_t;
endpackage

// File: rtl/lfm_period.sv
module lfm_period
  import lfm_pkg::*;
#(
  parameter int CYCLES_PER_MS = 50000,
  parameter int MS_W          = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            sig_i,
  output logic            done_o,
  output logic [MS_W-1:0] ms_o
);
  localparam int TICK_W = $clog2(CYCLES_PER_MS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CYCLES_PER_MS - 1);

  prd_state_t        state_q;
  logic [TICK_W-1:0] tick_q;
  logic [MS_W-1:0]   ms_q;
  logic              sig_q;
  logic              rise;

  assign rise = sig_i & ~sig_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= PRD_IDLE;
      tick_q  <= '0;
      ms_q    <= '0;
      sig_q   <= 1'b0;
    end else begin
      sig_q <= sig_i;
      case (state_q)
        PRD_IDLE:  if (start_i) state_q <= PRD_WAIT;
        PRD_WAIT: begin
          if (rise) begin
            // the edge cycle itself is the first counted cycle
            tick_q  <= TICK_W'(1);
            ms_q    <= '0;
            state_q <= PRD_COUNT;
          end
        end
        PRD_COUNT: begin
          if (rise) begin
            state_q <= PRD_DONE;
          end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            ms_q   <= ms_q + MS_W'(1);
          end else begin
            tick_q <= tick_q + TICK_W'(1);
          end
        end
        default:   state_q <= PRD_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == PRD_DONE);
  assign ms_o   = ms_q;

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    tick_q <= TICK_LAST); // R4
  AST_PRD_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
endmodule

// File: rtl/lfm_divider.sv
module lfm_divider
  import lfm_pkg::*;
#(
  parameter int W     = 20,
  parameter int OUT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     dvnd_i,
  input  logic [W-1:0]     dvsr_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(W + 1);

  div_state_t       state_q;
  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dvsr_q;
  logic [CNT_W-1:0] left_q;

  logic [W:0]   trial;
  logic [W:0]   diff;
  logic         fits;
  logic [W-1:0] rem_nxt;

  always_comb begin
    trial   = {rem_q, quo_q[W-1]};
    diff    = trial - {1'b0, dvsr_q};
    fits    = (trial >= {1'b0, dvsr_q});
    rem_nxt = fits ? diff[W-1:0] : trial[W-1:0];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= DIV_IDLE;
      rem_q   <= '0;
      quo_q   <= '0;
      dvsr_q  <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        DIV_IDLE: begin
          if (start_i) begin
            rem_q   <= '0;
            quo_q   <= dvnd_i;
            dvsr_q  <= dvsr_i;
            left_q  <= CNT_W'(W - 1);
            state_q <= DIV_OP;
          end
        end
        DIV_OP: begin
          rem_q  <= rem_nxt;
          quo_q  <= {quo_q[W-2:0], fits};
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_q <= DIV_LAST;
        end
        DIV_LAST: begin
          rem_q   <= rem_nxt;
          quo_q   <= {quo_q[W-2:0], fits};
          state_q <= DIV_DONE;
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == DIV_DONE);
  assign quo_o  = quo_q[OUT_W-1:0];

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (state_q != DIV_IDLE && dvsr_q != '0) |-> rem_q < dvsr_q); // R5
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
endmodule

// File: rtl/lfm_bin2bcd.sv
module lfm_bin2bcd
  import lfm_pkg::*;
#(
  parameter int BIN_W  = 13,
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [BIN_W-1:0]          bin_i,
  output logic                      done_o,
  output logic [DIGITS*DIGIT_W-1:0] bcd_o
);
  localparam int BCD_W = DIGITS * DIGIT_W;
  localparam int CNT_W = $clog2(BIN_W + 1);

  cnv_state_t       state_q;
  logic [BIN_W-1:0] bin_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] left_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] dig;
    assign dig = bcd_q[g*DIGIT_W +: DIGIT_W];
    assign adj[g*DIGIT_W +: DIGIT_W] = (dig >= 4'd5) ? dig + 4'd3 : dig;

    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
      dig <= 4'd9); // R6
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= CNV_IDLE;
      bin_q   <= '0;
      bcd_q   <= '0;
      left_q  <= '0;
    end else begin
      case (state_q)
        CNV_IDLE: begin
          if (start_i) begin
            bin_q   <= bin_i;
            bcd_q   <= '0;
            left_q  <= CNT_W'(BIN_W);
            state_q <= CNV_OP;
          end
        end
        CNV_OP: begin
          bcd_q  <= {adj[BCD_W-2:0], bin_q[BIN_W-1]};
          bin_q  <= {bin_q[BIN_W-2:0], 1'b0};
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_q <= CNV_DONE;
        end
        default: state_q <= CNV_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == CNV_DONE);
  assign bcd_o  = bcd_q;
endmodule

// File: rtl/lfm_meter.sv
module lfm_meter
  import lfm_pkg::*;
#(
  parameter int CYCLES_PER_MS = 50000,
  parameter int MS_W          = 10,
  parameter int DIV_W         = 20,
  parameter int DIVIDEND      = 100000,
  parameter int BIN_W         = 13,
  parameter int DIGITS        = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      sig_in,
  output logic                      ready,
  output logic                      done_tick,
  output logic [DIGITS*DIGIT_W-1:0] bcd_o
);
  localparam int BCD_W = DIGITS * DIGIT_W;
  localparam logic [DIV_W-1:0] DVND = DIV_W'(DIVIDEND);

  top_state_t       state_q;
  logic             prd_go, div_go, cnv_go, finish;
  logic             prd_done, div_done, cnv_done;
  logic [MS_W-1:0]  period_ms;
  logic [BIN_W-1:0] freq_bin;
  logic [BCD_W-1:0] cnv_bcd;
  logic [BCD_W-1:0] result_q;
  logic             done_q;

  assign prd_go = (state_q == TOP_IDLE)  && start;
  assign div_go = (state_q == TOP_COUNT) && prd_done;
  assign cnv_go = (state_q == TOP_FRQ)   && div_done;
  assign finish = (state_q == TOP_B2B)   && cnv_done;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q  <= TOP_IDLE;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) result_q <= cnv_bcd;
      case (state_q)
        TOP_IDLE:  if (prd_go) state_q <= TOP_COUNT;
        TOP_COUNT: if (div_go) state_q <= TOP_FRQ;
        TOP_FRQ:   if (cnv_go) state_q <= TOP_B2B;
        default:   if (finish) state_q <= TOP_IDLE;
      endcase
    end
  end

  lfm_period #(.CYCLES_PER_MS(CYCLES_PER_MS), .MS_W(MS_W)) u_period (
    .clk(clk), .rst(rst), .start_i(prd_go), .sig_i(sig_in),
    .done_o(prd_done), .ms_o(period_ms)
  );

  lfm_divider #(.W(DIV_W), .OUT_W(BIN_W)) u_divider (
    .clk(clk), .rst(rst), .start_i(div_go), .dvnd_i(DVND),
    .dvsr_i({{(DIV_W-MS_W){1'b0}}, period_ms}),
    .done_o(div_done), .quo_o(freq_bin)
  );

  lfm_bin2bcd #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_bin2bcd (
    .clk(clk), .rst(rst), .start_i(cnv_go), .bin_i(freq_bin),
    .done_o(cnv_done), .bcd_o(cnv_bcd)
  );

  assign ready     = (state_q == TOP_IDLE);
  assign done_tick = done_q;
  assign bcd_o     = result_q;

  AST_ONE_UNIT_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prd_done, div_done, cnv_done})); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_tick |=> !done_tick); // R7
  AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    done_tick |-> ready); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !done_tick |-> $stable(bcd_o)); // R8
endmodule

// File: tb/test_lfm_meter.sv
`timescale 1ns/1ps
module test_lfm_meter;
  localparam int CPM = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sig_in = 1'b0;
  logic        ready, done_tick;
  logic [15:0] bcd_o;

  int checks = 0;
  int fails  = 0;
  int done_seen = 0;
  logic [15:0] prev_result = 16'h0;

  always #2 clk = ~clk;

  lfm_meter #(.CYCLES_PER_MS(CPM)) i_lfm_meter (
    .clk(clk), .rst(rst), .start(start), .sig_in(sig_in),
    .ready(ready), .done_tick(done_tick), .bcd_o(bcd_o)
  );

  always @(negedge clk) if (!rst && done_tick) done_seen++;

  function automatic logic [15:0] expect_bcd(int pc);
    int ms = pc / CPM;
    int f  = 100000 / ms;
    return {4'(f / 1000 % 10), 4'(f / 100 % 10), 4'(f / 10 % 10), 4'(f % 10)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pc: input period in clocks, offset: start phase, again: second start while busy
  task automatic run_case(int pc, int offset, bit again);
    logic [15:0] exp = expect_bcd(pc);
    int seen_before = done_seen;
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          sig_in = 1'b0;
          repeat (pc - pc / 2) @(negedge clk);
          sig_in = 1'b1;
          repeat (pc / 2) @(negedge clk);
        end
        sig_in = 1'b0;
      end
      begin
        int c = 0;
        bit held = 1'b1;
        repeat (offset) @(negedge clk);
        check("R2 ready before start", ready, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 ready after start", ready, 0);
        while (!done_tick && c < 20 * pc) begin
          if (bcd_o !== prev_result) held = 1'b0;
          start = (again && c == pc / 2);
          @(negedge clk);
          c++;
        end
        start = 1'b0;
        check("R8 result held while busy", held, 1);
        check("R3 R5 R6 R10 digits", bcd_o, exp);
        check("R7 ready with done", ready, 1);
        @(negedge clk);
        check("R7 done one cycle", done_tick, 0);
        check("R2 one result per start", done_seen - seen_before, 1);
        prev_result = exp;
      end
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 ready in reset", ready, 1);
    check("R1 done in reset", done_tick, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ready after reset", ready, 1);
    check("R1 digits after reset", bcd_o, 16'h0);
    check("R1 done after reset", done_tick, 0);

    run_case(100 * CPM, 3, 1'b0);                 // 10 Hz -> 1000
    run_case(1000 * CPM + 1, 7, 1'b0);            // 1 Hz  -> 0100
    run_case(333 * CPM, 333 * CPM / 2 + 5, 1'b0); // R10 start in high phase
    run_case(101 * CPM + 1, 11, 1'b1);            // R2 ignored second start
    run_case(999 * CPM, 20, 1'b0);
    for (int i = 0; i < 5; i++) begin
      int p  = 100 + int'($urandom % 901);
      int pc = p * CPM + int'($urandom % CPM);
      run_case(pc, int'($urandom % pc), 1'(($urandom % 2)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule